// File: doc/BRIEF.md
# Haar Level Output Scatter Scheduler

This block sits behind a four-lane 2D Haar kernel. Each input beat carries the four results of one 2x2 kernel step: the low-low, low-high, high-low and high-high coefficients. The block writes each of them to its place in an internal image-sized store. When one decomposition level is finished, the store holds that level's subband layout: the approximation quadrant is at the top left, the horizontal-detail quadrant to its right, the vertical-detail quadrant below it and the diagonal-detail quadrant diagonally across from it. The block then streams the whole image out, four coefficients per beat, in plain row-major order.

The level is sampled on a `start` pulse. At level L only the top-left square of side `IMG_W >> L` is rewritten. The rest of the store keeps the detail subbands from earlier levels, so running levels 0, 1, 2 in turn leaves a complete multilevel layout in the store. Storage is split into four banks. A level-independent swizzle picks the bank, so the four scattered writes of a beat never share a bank, and neither do the four reads of an output beat.

Both data interfaces are valid/ready. On the input side a beat is taken only in a cycle where `s_valid` and `s_ready` are both high. If `s_valid` is low, the beat count does not advance. On the output side the presented beat stays in place until `m_ready` is high. The two phases never overlap. `start` and `level` are plain control pins, and `done` is a plain pulse.

Top module: `haar_out_scatter`

## Requirements
- R1: After reset, `s_ready`, `m_valid` and `done` are all low, and the block waits for `start`.
- R2: A `start` pulse while idle captures `level` and opens the fill phase. During fill `s_ready` is high, and exactly (IMG_W >> (L+1))^2 beats are accepted. A beat counts only when `s_valid` is high.
- R3: For accepted beat j with half-width h = IMG_W >> (L+1), let r = j >> log2(h) and c = j & (h-1). Lane 0 (bits [DW-1:0], low-low) goes to (r,c). Lane 1 (low-high) goes to (r,c+h). Lane 2 (high-low) goes to (r+h,c). Lane 3 (high-high) goes to (r+h,c+h).
- R4: Store entries outside the active square of side IMG_W >> L keep the values written by earlier fills.
- R5: In the cycle after the last fill beat is accepted, `m_valid` rises and `s_ready` falls. The output is the whole IMG_W x IMG_W store as IMG_W*IMG_W/4 beats in row-major order. Beat k, lane q (bits [q*DW +: DW]) carries element k*4+q.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change.
- R7: `done` is high for exactly one cycle, the cycle after the final output handshake. In that cycle the block is already idle.
- R8: A `start` pulse during fill or drain has no effect on the beat counts, the data or the phase.
- R9: A `level` above IMG_W's log2 minus 3 is treated as that maximum level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a level when idle |
| level | input | $clog2($clog2(IMG_W)) | Decomposition level, sampled with start |
| s_valid | input | 1 | Kernel beat valid |
| s_ready | output | 1 | High during the fill phase |
| s_data | input | 4*DW | Kernel lanes low-low, low-high, high-low, high-high from the LSB |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 4*DW | Four consecutive row-major coefficients, lowest column in the LSBs |
| done | output | 1 | One-cycle pulse after the final output beat |

## Verification
The hardest situation to reach from the ports is a store that mixes results of different levels. Showing that entries outside the active square survive requires a deeper level to run after a shallower one, and then the whole image must be read back. The stimulus chains full-image level-0 fills with level-1, level-2 and clamped-level runs under random valid and ready stalls. A bench image model is updated from the R3 mapping alone, and every output beat is compared against it. Selected runs also pulse `start` in the middle of fill and drain, to show that the pulse has no effect.

// File: rtl/haar_out_scatter_pkg.sv
package haar_out_scatter_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_DRAIN} phase_e;
  localparam int LANES = 4;
endpackage

// File: rtl/hos_wr_sched.sv
// Write-side scatter: turns one kernel beat into four bank writes.
module hos_wr_sched
  import haar_out_scatter_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LOG_W    = 5,
  parameter int LVL_BITS = 3,
  localparam int AW      = 2*LOG_W-2
) (
  input  logic [LVL_BITS-1:0]         lvl,
  input  logic [AW-1:0]               beat,
  input  logic                        en,
  input  logic [LANES*DW-1:0]         din,
  output logic [LANES-1:0]            we,
  output logic [LANES-1:0][AW-1:0]    widx,
  output logic [LANES-1:0][DW-1:0]    wdat
);
  logic [LVL_BITS-1:0]             hsh;
  logic [LOG_W-1:0]                half, r, c;
  logic [LANES-1:0][LOG_W-1:0]     row_l, col_l;
  logic [LANES-1:0][1:0]           bank_l;

  // log2 of the half width: all scaling is by shifts
  assign hsh  = LVL_BITS'(LOG_W-1) - lvl;
  assign half = LOG_W'(1) << hsh;
  assign r    = LOG_W'(beat >> hsh);
  assign c    = LOG_W'(beat) & (half - LOG_W'(1));

  generate
    for (genvar q = 0; q < LANES; q++) begin : g_lane
      localparam bit QR = ((q >> 1) & 1) == 1;
      localparam bit QC = (q & 1) == 1;
      assign row_l[q]  = r | (QR ? half : '0);
      assign col_l[q]  = c | (QC ? half : '0);
      // bank swizzle independent of level: quadrant offsets flip a parity
      assign bank_l[q] = col_l[q][1:0] ^ {^row_l[q], ^col_l[q][LOG_W-1:2]};
    end
  endgenerate

  always_comb begin
    we   = '0;
    widx = '0;
    wdat = '0;
    for (int q = 0; q < LANES; q++) begin
      we[bank_l[q]]   = en;
      widx[bank_l[q]] = {row_l[q], col_l[q][LOG_W-1:2]};
      wdat[bank_l[q]] = din[q*DW +: DW];
    end
  end
endmodule

// File: rtl/hos_bank.sv
// One storage bank: synchronous write, combinational read.
module hos_bank #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdat,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdat
);
  logic [DW-1:0] mem [1<<AW];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  assign rdat = mem[ridx];
endmodule

// File: rtl/hos_rd_sched.sv
// Sequential read-out: undoes the bank swizzle for one row-major beat.
module hos_rd_sched
  import haar_out_scatter_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LOG_W = 5,
  localparam int AW   = 2*LOG_W-2
) (
  input  logic [AW-1:0]            beat,
  input  logic [LANES-1:0][DW-1:0] rdat,
  output logic [AW-1:0]            ridx,
  output logic [LANES*DW-1:0]      dout
);
  logic [1:0] swz;

  assign swz  = {^beat[AW-1:LOG_W-2], ^beat[LOG_W-3:0]};
  assign ridx = beat;

  generate
    for (genvar q = 0; q < LANES; q++) begin : g_lane
      assign dout[q*DW +: DW] = rdat[2'(q) ^ swz];
    end
  endgenerate
endmodule

// File: rtl/haar_out_scatter.sv
module haar_out_scatter
  import haar_out_scatter_pkg::*;
#(
  parameter int DW        = 16,
  parameter int IMG_W     = 32,
  localparam int LOG_W    = $clog2(IMG_W),
  localparam int LVL_BITS = $clog2(LOG_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LVL_BITS-1:0]     level,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [LANES*DW-1:0]     s_data,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [LANES*DW-1:0]     m_data,
  output logic                    done
);
  localparam int MAX_LVL = LOG_W - 3;
  localparam int AW      = 2*LOG_W - 2;

  phase_e                      ph;
  logic [AW-1:0]               cnt;
  logic [LVL_BITS-1:0]         lvl_q, lvl_eff;
  logic [AW-1:0]               fill_last;
  logic                        done_q, wr_en;
  logic [LANES-1:0]            we_b;
  logic [LANES-1:0][AW-1:0]    widx_b;
  logic [LANES-1:0][DW-1:0]    wdat_b, rdat_b;
  logic [AW-1:0]               ridx;

  assign lvl_eff   = (level > LVL_BITS'(MAX_LVL)) ? LVL_BITS'(MAX_LVL) : level;
  // beats per level = 4^(LOG_W-1-L): all-ones shifted by 2L
  assign fill_last = {AW{1'b1}} >> {lvl_q, 1'b0};
  assign wr_en     = (ph == PH_FILL) && s_valid;
  assign s_ready   = (ph == PH_FILL);
  assign m_valid   = (ph == PH_DRAIN);
  assign done      = done_q;

  hos_wr_sched #(.DW(DW), .LOG_W(LOG_W), .LVL_BITS(LVL_BITS)) u_wr (
    .lvl(lvl_q), .beat(cnt), .en(wr_en), .din(s_data),
    .we(we_b), .widx(widx_b), .wdat(wdat_b)
  );

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_bank
      hos_bank #(.DW(DW), .AW(AW)) u_bank (
        .clk(clk), .we(we_b[b]), .widx(widx_b[b]), .wdat(wdat_b[b]),
        .ridx(ridx), .rdat(rdat_b[b])
      );
    end
  endgenerate

  hos_rd_sched #(.DW(DW), .LOG_W(LOG_W)) u_rd (
    .beat(cnt), .rdat(rdat_b), .ridx(ridx), .dout(m_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      lvl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          lvl_q <= lvl_eff;
          cnt   <= '0;
          ph    <= PH_FILL;
        end
        PH_FILL: if (s_valid) begin
          if (cnt == fill_last) begin
            cnt <= '0;
            ph  <= PH_DRAIN;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        PH_DRAIN: if (m_ready) begin
          if (cnt == {AW{1'b1}}) begin
            cnt    <= '0;
            ph     <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/haar_out_scatter_chk.sv
module haar_out_scatter_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [4*DW-1:0] m_data,
  input logic          done
);
  p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  p_drain_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready));

  p_fill_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(start));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!s_ready && !m_valid));
endmodule

bind haar_out_scatter haar_out_scatter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
  .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .done(done)
);

// File: tb/haar_out_scatter_tb.sv
module haar_out_scatter_tb;
  localparam int DW = 16;
  localparam int W  = 32;
  localparam int NB_OUT = W*W/4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] level = '0;
  logic s_valid = 1'b0, s_ready;
  logic [4*DW-1:0] s_data = '0;
  logic m_valid, m_ready = 1'b0, done;
  logic [4*DW-1:0] m_data;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [W*W];

  always #2 clk = ~clk;

  haar_out_scatter #(.DW(DW), .IMG_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .done(done)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int clamp_lvl(input int l);
    return (l > 2) ? 2 : l;
  endfunction

  task automatic run_level(input int lvl_in, input int vstall, input int rstall,
                           input bit poke, input string tag);
    int L, hl, h, nb, j, k;
    logic [4*DW-1:0] held, e;
    bit stalled;
    L = clamp_lvl(lvl_in); hl = 4 - L; h = 1 << hl; nb = h*h; j = 0; k = 0;
    stalled = 1'b0;
    @(negedge clk);
    chk(!s_ready && !m_valid, "R8 idle before start", {s_ready, m_valid}, 0);
    start = 1'b1; level = 3'(lvl_in);
    @(negedge clk);
    start = 1'b0;
    chk(s_ready == 1'b1, {tag, " R2 fill opened"}, s_ready, 1);
    while (j < nb) begin
      s_valid = ($urandom % 100) >= vstall;
      s_data  = {$urandom, $urandom};
      if (poke && j == 3) begin start = 1'b1; level = 3'd0; end
      else start = 1'b0;
      if (s_valid && s_ready) begin
        for (int q = 0; q < 4; q++) begin
          int row, col;
          row = (j >> hl) + ((q >> 1) * h);
          col = (j & (h-1)) + ((q & 1) * h);
          model[row*W + col] = s_data[q*DW +: DW];
        end
        j++;
      end
      @(negedge clk);
    end
    s_valid = 1'b0; start = 1'b0;
    chk(m_valid && !s_ready, {tag, " R2 R5 R8 fill length and drain entry"}, {m_valid, s_ready}, 2'b10);
    while (k < NB_OUT) begin
      m_ready = ($urandom % 100) >= rstall;
      if (poke && k == 10) begin start = 1'b1; level = 3'd1; end
      else start = 1'b0;
      if (stalled) chk(m_data == held && m_valid, "R6 output held under back-pressure", m_data, held);
      if (m_ready) begin
        for (int q = 0; q < 4; q++) e[q*DW +: DW] = model[k*4 + q];
        chk(m_data == e && m_valid, {tag, " R3 R4 R5 R8 output beat"}, m_data, e);
        k++;
        stalled = 1'b0;
      end else begin
        held = m_data;
        stalled = 1'b1;
      end
      @(negedge clk);
    end
    m_ready = 1'b0; start = 1'b0;
    chk(done && !m_valid && !s_ready, "R7 done pulse after last beat", {done, m_valid, s_ready}, 3'b100);
    @(negedge clk);
    chk(!done && !m_valid && !s_ready, "R7 R8 single pulse then idle", {done, m_valid, s_ready}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < W*W; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready && !m_valid && !done, "R1 reset state", {s_ready, m_valid, done}, 0);
    run_level(0, 0, 0, 1'b0, "lvl0 directed");
    run_level(1, 30, 30, 1'b0, "lvl1");
    run_level(2, 50, 50, 1'b1, "lvl2 poke");
    run_level(6, 20, 60, 1'b0, "R9 clamp");
    run_level(0, 40, 40, 1'b1, "lvl0 poke");
    run_level(1, 0, 0, 1'b0, "lvl1 directed");
    run_level(2, 10, 10, 1'b0, "lvl2");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule